// File: doc/BRIEF.md
# Four-Way Set-Associative TLB with Test Port

This block caches page translations in eight sets of four ways. Each entry holds a 20-bit linear page tag, a 20-bit physical frame and four attribute bits: valid, dirty, user and writable. The translation port is purely combinational. A request with a linear page number gets the frame and attributes back in the same cycle, together with a hit flag. The set is chosen by the low three bits of the page number.

A test port lets software place and inspect entries directly. It consists of two readable registers: a command word and a data word. Writing the command word either installs an entry or runs an associative probe at once, depending on its command bit. The probe accepts don't-care attribute masks and reports a hit only when exactly one entry matches.

The test port is usable only while address translation is switched off. A bulk-flush input, pulsed whenever the page-directory base changes, invalidates the whole array.

Top module: `tlb4_testport`

## Requirements
- R1: After reset, every entry is invalid, every replacement pointer is 0, and both test registers read 0.
- R2: The data word holds the frame in bits 31:12, the placement-select flag (SEL) in bit 4 and the way number (WAYNO) in bits 3:2. The command word holds the tag in bits 31:12, the valid bit in bit 11, the dirty pair in bits 10:9, the user pair in bits 8:7, the writable pair in bits 6:5 and the command bit in bit 0. All other bits of both words read back as 0.
- R3: A command write with bit 0 = 0 installs an entry. The set is tag bits 2:0. The entry takes its tag and valid bit from the command word and its frame from the data word as it stood before that cycle. Each attribute pair (value, complement) stores 1 for 10 and 0 for 01, 00 or 11.
- R4: An install with SEL = 1 writes the way given by WAYNO, whatever the set's pointer holds, and leaves that pointer unchanged.
- R5: An install with SEL = 0 writes the way named by the set's own pointer. The pointer then advances 0,1,2,3,0.
- R6: A translation hits only while the request is high and a valid entry in the indexed set has an equal tag. If several entries match, the lowest-numbered way supplies the frame and attributes.
- R7: A command write with bit 0 = 1 probes the set given by the tag. When exactly one valid entry matches, the following fields are loaded:
  - in the data word: SEL = 1, WAYNO = the matching way, frame = that entry's frame;
  - in the command word: the valid bit = 1, and each attribute pair = (stored bit, its inverse).
- R8: In a probe, an attribute pair of 00 matches nothing, 01 matches a stored 0, 10 matches a stored 1, and 11 matches either value.
- R9: A probe that matches no entry, or more than one, clears SEL and leaves the frame and WAYNO unchanged.
- R10: While translation is enabled, writes to both test registers are ignored and change no entry.
- R11: A flush pulse clears every valid bit, so every translation in the following cycle misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| paging_on | input | 1 | Translation enabled; locks the test port |
| flush_all | input | 1 | Invalidate every entry |
| xl_req | input | 1 | Translation request |
| xl_page | input | 20 | Linear page number to translate |
| xl_hit | output | 1 | Translation hit |
| xl_frame | output | 20 | Physical frame of the hit |
| xl_dirty | output | 1 | Dirty attribute of the hit |
| xl_user | output | 1 | User attribute of the hit |
| xl_wrok | output | 1 | Writable attribute of the hit |
| tcmd_wr | input | 1 | Command word write strobe |
| tcmd_wdata | input | 32 | Command word write value |
| tdat_wr | input | 1 | Data word write strobe |
| tdat_wdata | input | 32 | Data word write value |
| tcmd | output | 32 | Command word readback |
| tdat | output | 32 | Data word readback |

## Verification
The translation table is run against one set after it has been filled in several ways:
- entries placed by force and entries placed by the pointer;
- an entry installed invalid;
- entries evicted when the pointer wraps;
- pages that share a set index but differ in tag.

These cases separate placement from eviction and valid from invalid. Probes then vary the attribute masks, each pair in turn:
- 11 matches any stored value;
- 01 rejects a stored 1;
- 00 rejects everything.

A second set holds two entries with the same tag. On that set, a full-wildcard probe must miss because two entries match, while a narrowing mask must hit one way. The same duplicates show which way the translation port favours. The remaining cases each isolate one effect:
- masked bits read back as 0;
- writes made while translation is on are blocked;
- a flush takes effect on the next cycle.

// File: rtl/tlb4_testport.sv
module tlb4_testport #(
  parameter int TAG_W = 20,
  parameter int SETS  = 8,
  parameter int WAYS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              paging_on,
  input  logic              flush_all,
  input  logic              xl_req,
  input  logic [TAG_W-1:0]  xl_page,
  output logic              xl_hit,
  output logic [TAG_W-1:0]  xl_frame,
  output logic              xl_dirty,
  output logic              xl_user,
  output logic              xl_wrok,
  input  logic              tcmd_wr,
  input  logic [TAG_W+11:0] tcmd_wdata,
  input  logic              tdat_wr,
  input  logic [TAG_W+11:0] tdat_wdata,
  output logic [TAG_W+11:0] tcmd,
  output logic [TAG_W+11:0] tdat
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int WORD_W = TAG_W + 12;
  localparam logic [WORD_W-1:0] CMD_MASK = {{TAG_W{1'b1}}, 7'b1111111, 4'b0000, 1'b1};
  localparam logic [WORD_W-1:0] DAT_MASK = {{TAG_W{1'b1}}, 7'b0000000, 1'b1, 2'b11, 2'b00};

  logic [TAG_W-1:0] tag_r  [SETS][WAYS];
  logic [TAG_W-1:0] phys_r [SETS][WAYS];
  logic [WAYS-1:0]  vld_r  [SETS];
  logic [WAYS-1:0]  d_r    [SETS];
  logic [WAYS-1:0]  u_r    [SETS];
  logic [WAYS-1:0]  w_r    [SETS];
  logic [WAY_W-1:0] ptr_r  [SETS];

  wire [IDX_W-1:0] xs   = xl_page[IDX_W-1:0];
  wire [TAG_W-1:0] ltag = tcmd_wdata[WORD_W-1:12];
  wire [IDX_W-1:0] ts   = tcmd_wdata[12 +: IDX_W];
  wire             port_ok = !paging_on;
  wire             sel_f   = tdat[4];
  wire [WAY_W-1:0] wway    = sel_f ? tdat[2 +: WAY_W] : ptr_r[ts];

  wire d_val = tcmd_wdata[10], d_cmp = tcmd_wdata[9];
  wire u_val = tcmd_wdata[8],  u_cmp = tcmd_wdata[7];
  wire w_val = tcmd_wdata[6],  w_cmp = tcmd_wdata[5];

  always_comb begin
    logic found;
    found    = 1'b0;
    xl_frame = '0;
    xl_dirty = 1'b0;
    xl_user  = 1'b0;
    xl_wrok  = 1'b0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (vld_r[xs][w] && tag_r[xs][w] == xl_page) begin
        found    = 1'b1;
        xl_frame = phys_r[xs][w];
        xl_dirty = d_r[xs][w];
        xl_user  = u_r[xs][w];
        xl_wrok  = w_r[xs][w];
      end
    end
    xl_hit = xl_req && found;
  end

  logic [WAYS-1:0]  lmatch;
  logic [WAY_W:0]   lcnt;
  logic [WAY_W-1:0] lway;

  always_comb begin
    lcnt = '0;
    lway = '0;
    for (int w = 0; w < WAYS; w++) begin
      lmatch[w] = vld_r[ts][w] && tag_r[ts][w] == ltag &&
                  ((d_val && d_r[ts][w]) || (d_cmp && !d_r[ts][w])) &&
                  ((u_val && u_r[ts][w]) || (u_cmp && !u_r[ts][w])) &&
                  ((w_val && w_r[ts][w]) || (w_cmp && !w_r[ts][w]));
      if (lmatch[w]) begin
        lcnt = lcnt + 1'b1;
        lway = WAY_W'(w);
      end
    end
  end

  wire lhit = (lcnt == 1);
  wire do_install = tcmd_wr && port_ok && !tcmd_wdata[0];
  wire do_probe   = tcmd_wr && port_ok &&  tcmd_wdata[0];

  always_ff @(posedge clk) begin
    if (do_install) begin
      tag_r[ts][wway]  <= ltag;
      phys_r[ts][wway] <= tdat[WORD_W-1:12];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_r[s] <= '0;
        d_r[s]   <= '0;
        u_r[s]   <= '0;
        w_r[s]   <= '0;
        ptr_r[s] <= '0;
      end
      tcmd <= '0;
      tdat <= '0;
    end else begin
      if (flush_all)
        for (int s = 0; s < SETS; s++) vld_r[s] <= '0;
      if (tdat_wr && port_ok)
        tdat <= tdat_wdata & DAT_MASK;
      if (tcmd_wr && port_ok)
        tcmd <= tcmd_wdata & CMD_MASK;
      if (do_install) begin
        vld_r[ts][wway] <= tcmd_wdata[11];
        d_r[ts][wway]   <= d_val && !d_cmp;
        u_r[ts][wway]   <= u_val && !u_cmp;
        w_r[ts][wway]   <= w_val && !w_cmp;
        if (!sel_f) ptr_r[ts] <= ptr_r[ts] + 1'b1;
      end
      if (do_probe) begin
        if (lhit) begin
          tcmd[11:5] <= {1'b1, d_r[ts][lway], !d_r[ts][lway], u_r[ts][lway],
                         !u_r[ts][lway], w_r[ts][lway], !w_r[ts][lway]};
          tdat[WORD_W-1:12] <= phys_r[ts][lway];
          tdat[4]           <= 1'b1;
          tdat[2 +: WAY_W]  <= lway;
        end else begin
          tdat[4] <= 1'b0;
        end
      end
    end
  end
endmodule

module tlb4_testport_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              paging_on,
  input logic              flush_all,
  input logic              xl_req,
  input logic              xl_hit,
  input logic              tcmd_wr,
  input logic [WORD_W-1:0] tcmd_wdata,
  input logic [WORD_W-1:0] tcmd,
  input logic [WORD_W-1:0] tdat
);
  // R6
  no_req_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |-> !xl_hit);

  // R11
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !tcmd_wr) |=> !xl_hit);

  // R10
  port_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paging_on |=> ($stable(tcmd) && $stable(tdat)));

  // R2
  dat_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tdat[11:5] == 7'd0 && tdat[1:0] == 2'd0 && tcmd[4:1] == 4'd0));

  // R7
  probe_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tcmd_wr && !paging_on && tcmd_wdata[0]) |=>
      (tcmd[WORD_W-1:12] == $past(tcmd_wdata[WORD_W-1:12]) && tcmd[0] &&
       (!tdat[4] || (tcmd[11] && tcmd[10] != tcmd[9] &&
                     tcmd[8] != tcmd[7] && tcmd[6] != tcmd[5]))));
endmodule

bind tlb4_testport tlb4_testport_chk #(.WORD_W(TAG_W + 12)) u_chk (
  .clk(clk), .rst_n(rst_n), .paging_on(paging_on), .flush_all(flush_all),
  .xl_req(xl_req), .xl_hit(xl_hit), .tcmd_wr(tcmd_wr),
  .tcmd_wdata(tcmd_wdata), .tcmd(tcmd), .tdat(tdat));

// File: tb/tlb4_testport_test.sv
`timescale 1ns/1ps
module tlb4_testport_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic paging_on = 1'b0, flush_all = 1'b0, xl_req = 1'b0;
  logic [19:0] xl_page = '0;
  logic xl_hit, xl_dirty, xl_user, xl_wrok;
  logic [19:0] xl_frame;
  logic tcmd_wr = 1'b0, tdat_wr = 1'b0;
  logic [31:0] tcmd_wdata = '0, tdat_wdata = '0, tcmd, tdat;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tlb4_testport uut (
    .clk(clk), .rst_n(rst_n), .paging_on(paging_on), .flush_all(flush_all),
    .xl_req(xl_req), .xl_page(xl_page), .xl_hit(xl_hit), .xl_frame(xl_frame),
    .xl_dirty(xl_dirty), .xl_user(xl_user), .xl_wrok(xl_wrok),
    .tcmd_wr(tcmd_wr), .tcmd_wdata(tcmd_wdata), .tdat_wr(tdat_wr),
    .tdat_wdata(tdat_wdata), .tcmd(tcmd), .tdat(tdat));

  function automatic logic [31:0] mk_cmd(logic [19:0] tag, logic v, logic [1:0] dp,
                                         logic [1:0] up, logic [1:0] wp, logic c);
    return {tag, v, dp, up, wp, 4'b0000, c};
  endfunction

  function automatic logic [31:0] mk_dat(logic [19:0] ph, logic sel, logic [1:0] way);
    return {ph, 7'd0, sel, way, 2'b00};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_dat(logic [31:0] v);
    @(negedge clk); tdat_wr = 1'b1; tdat_wdata = v;
    @(negedge clk); tdat_wr = 1'b0;
  endtask

  task automatic wr_cmd(logic [31:0] v);
    @(negedge clk); tcmd_wr = 1'b1; tcmd_wdata = v;
    @(negedge clk); tcmd_wr = 1'b0;
  endtask

  task automatic install(logic [19:0] tag, logic [19:0] ph, logic v, logic [1:0] dp,
                         logic [1:0] up, logic [1:0] wp, logic sel, logic [1:0] way);
    wr_dat(mk_dat(ph, sel, way));
    wr_cmd(mk_cmd(tag, v, dp, up, wp, 1'b0));
  endtask

  task automatic xlate(string req, logic rq, logic [19:0] pg, logic eh,
                       logic [19:0] ef, logic [2:0] eattr);
    @(negedge clk); xl_req = rq; xl_page = pg; #1;
    check(req, 64'(xl_hit), 64'(eh));
    if (eh) check(req, 64'({xl_frame, xl_dirty, xl_user, xl_wrok}), 64'({ef, eattr}));
  endtask

  // {req, page, hit, frame, dirty, user, writable}
  localparam logic [44:0] VEC [10] = '{
    {1'b1, 20'h00045, 1'b1, 20'h55555, 3'b111},
    {1'b1, 20'h00015, 1'b1, 20'h22222, 3'b001},
    {1'b1, 20'h00025, 1'b0, 20'h00000, 3'b000},
    {1'b1, 20'h00035, 1'b1, 20'h44444, 3'b000},
    {1'b1, 20'h12345, 1'b0, 20'h00000, 3'b000},
    {1'b1, 20'h00005, 1'b0, 20'h00000, 3'b000},
    {1'b1, 20'h7FFF2, 1'b1, 20'h0F0F0, 3'b110},
    {1'b1, 20'h7FFF5, 1'b0, 20'h00000, 3'b000},
    {1'b0, 20'h00045, 1'b0, 20'h00000, 3'b000},
    {1'b1, 20'h00042, 1'b0, 20'h00000, 3'b000}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] cmd_save, dat_save;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 tcmd", 64'(tcmd), 64'h0);
    check("R1 tdat", 64'(tdat), 64'h0);
    xlate("R1 empty", 1'b1, 20'h00000, 1'b0, 20'h0, 3'b0);

    // R2 masking
    wr_dat(32'hFFFF_FFFF);
    check("R2 dat mask", 64'(tdat), 64'hFFFF_F01C);

    // R3, R4: forced way 3 and pointer way 0 in set 5
    install(20'h12345, 20'hABCDE, 1'b1, 2'b10, 2'b01, 2'b10, 1'b1, 2'd3);
    install(20'h00005, 20'h11111, 1'b1, 2'b01, 2'b10, 2'b01, 1'b0, 2'd0);
    xlate("R3 R4 forced", 1'b1, 20'h12345, 1'b1, 20'hABCDE, 3'b101);
    xlate("R3 ptr", 1'b1, 20'h00005, 1'b1, 20'h11111, 3'b010);

    // R5: pointer 1,2,3 then wrap to 0
    wr_dat(mk_dat(20'h22222, 1'b0, 2'd0));
    wr_cmd(32'hFFFF_FFFE & mk_cmd(20'h00015, 1'b1, 2'b00, 2'b11, 2'b10, 1'b0) | 32'h0000_001E);
    check("R2 cmd mask", 64'(tcmd), 64'(mk_cmd(20'h00015, 1'b1, 2'b00, 2'b11, 2'b10, 1'b0)));
    install(20'h00025, 20'h33333, 1'b0, 2'b10, 2'b10, 2'b10, 1'b0, 2'd0);
    install(20'h00035, 20'h44444, 1'b1, 2'b01, 2'b01, 2'b01, 1'b0, 2'd0);
    install(20'h00045, 20'h55555, 1'b1, 2'b10, 2'b10, 2'b10, 1'b0, 2'd0);
    install(20'h7FFF2, 20'h0F0F0, 1'b1, 2'b10, 2'b10, 2'b01, 1'b1, 2'd0);

    // R6 R5 R3: translation table
    for (int i = 0; i < 10; i++)
      xlate($sformatf("R6 vec%0d", i), VEC[i][44], VEC[i][43:24], VEC[i][23],
            VEC[i][22:3], VEC[i][2:0]);
    xl_req = 1'b0;

    // R7 R8: full wildcard probe
    wr_cmd(mk_cmd(20'h00015, 1'b0, 2'b11, 2'b11, 2'b11, 1'b1));
    check("R7 probe dat", 64'(tdat), 64'(mk_dat(20'h22222, 1'b1, 2'd1)));
    check("R7 probe cmd", 64'(tcmd), 64'(mk_cmd(20'h00015, 1'b1, 2'b01, 2'b01, 2'b10, 1'b1)));
    // R8 R9: writable pair 01 rejects stored 1
    wr_cmd(mk_cmd(20'h00015, 1'b0, 2'b11, 2'b11, 2'b01, 1'b1));
    check("R8 R9 mask miss", 64'(tdat), 64'(mk_dat(20'h22222, 1'b0, 2'd1)));
    // R8: pair 00 never matches
    wr_cmd(mk_cmd(20'h00035, 1'b0, 2'b00, 2'b11, 2'b11, 1'b1));
    check("R8 pair00", 64'(tdat[4]), 64'h0);
    // R8: pair 01 matches stored 0
    wr_cmd(mk_cmd(20'h00035, 1'b0, 2'b01, 2'b01, 2'b01, 1'b1));
    check("R8 pair01", 64'(tdat), 64'(mk_dat(20'h44444, 1'b1, 2'd3)));

    // R9: duplicate tags in set 2
    install(20'h7FFF2, 20'h0AAAA, 1'b1, 2'b10, 2'b10, 2'b10, 1'b1, 2'd1);
    wr_cmd(mk_cmd(20'h7FFF2, 1'b0, 2'b11, 2'b11, 2'b11, 1'b1));
    check("R9 two match", 64'(tdat), 64'(mk_dat(20'h0AAAA, 1'b0, 2'd1)));
    wr_cmd(mk_cmd(20'h7FFF2, 1'b0, 2'b11, 2'b11, 2'b01, 1'b1));
    check("R7 narrowed", 64'(tdat), 64'(mk_dat(20'h0F0F0, 1'b1, 2'd0)));
    check("R7 narrowed cmd", 64'(tcmd), 64'(mk_cmd(20'h7FFF2, 1'b1, 2'b10, 2'b10, 2'b01, 1'b1)));
    xlate("R6 lowest way", 1'b1, 20'h7FFF2, 1'b1, 20'h0F0F0, 3'b110);

    // R10: test port locked while paging on
    cmd_save = tcmd; dat_save = tdat;
    paging_on = 1'b1;
    wr_dat(mk_dat(20'h99999, 1'b1, 2'd2));
    wr_cmd(mk_cmd(20'h00025, 1'b1, 2'b10, 2'b10, 2'b10, 1'b0));
    wr_cmd(mk_cmd(20'h00045, 1'b0, 2'b11, 2'b11, 2'b11, 1'b1));
    check("R10 tcmd", 64'(tcmd), 64'(cmd_save));
    check("R10 tdat", 64'(tdat), 64'(dat_save));
    xlate("R10 no install", 1'b1, 20'h00025, 1'b0, 20'h0, 3'b0);
    paging_on = 1'b0;

    // R11: flush
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    xlate("R11 flush a", 1'b1, 20'h00045, 1'b0, 20'h0, 3'b0);
    xlate("R11 flush b", 1'b1, 20'h7FFF2, 1'b0, 20'h0, 3'b0);
    xl_req = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule